// File: doc/BRIEF.md
# Partitioned RAM Record Copy Controller

This controller shares one single-port, byte-wide RAM between a display register and a copy engine. It runs on a fast clock. Each slow step lasts eight fast cycles. The top address bit splits the RAM into two halves: the lower half holds source bytes that are never written, and the upper half receives the copies.

While record mode is on, every step copies one byte. The controller reads the byte at the source counter, keeps it in an internal holding register, and then writes it at the destination counter. After the write, both counters advance. Each step also has one slot in which the display register loads a new value. All the other cycles leave the RAM idle.

Each half has its own counter. A section clear resets only the counter of the half that is selected. The asynchronous global reset resets both counters and the rest of the block.

Top module: `rec_copy_ctrl`

## Requirements
- R1: While `rst_n` is low, `ram_ce`, `ram_we` and `led_out` are 0. The cycle in which `rst_n` is released is phase 0. Phases then count 0..7 and repeat.
- R2: `led_out` takes the value of `led_in` at the clock edge that ends phase 0. It holds that value through all other phases.
- R3: In phase 2, if `rec_en` is 1, the controller issues a read: `ram_ce`=1, `ram_we`=0, `ram_addr`={1'b0, source counter}.
- R4: The byte on `ram_rdata` during phase 3 is written in phase 5 of a step that read in phase 2. In that cycle `ram_ce`=1, `ram_we`=1, `ram_addr`={1'b1, destination counter} and `ram_wdata` is the byte. `ram_we` is high for exactly one cycle per copy.
- R5: `ram_we` is never 1 while `ram_addr[ADDR_W-1]` is 0. `ram_ce` is 0 in every phase except 2 and 5.
- R6: After each copy, both counters increase by one. Each counter wraps from 2^(ADDR_W-1)-1 to 0.
- R7: If `rec_en` is 0 in phase 2, the step makes no RAM access and the counters keep their values.
- R8: `sec_clr`=1 at a clock edge clears the source counter when `sec_sel`=0, or the destination counter when `sec_sel`=1. The other counter is unaffected. Global reset clears both counters.
- R9: If a section clear and the post-copy increment meet at the same edge (the end of phase 5), the selected counter becomes 0 and the other counter still increments.
- R10: The write in phase 5 follows the `rec_en` value seen in phase 2. Changes to `rec_en` during phases 3..5 do not affect that step's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| rec_en | input | 1 | Record mode enable |
| sec_sel | input | 1 | Half selected for a section clear: 0 source, 1 destination |
| sec_clr | input | 1 | Synchronous clear of the selected half's counter |
| led_in | input | DATA_W | Value loaded into the display register in phase 0 |
| ram_rdata | input | DATA_W | RAM read data, valid the cycle after a read |
| ram_addr | output | ADDR_W | RAM address; the top bit selects the half |
| ram_wdata | output | DATA_W | RAM write data (the held byte) |
| ram_we | output | 1 | RAM write enable |
| ram_ce | output | 1 | RAM chip enable |
| led_out | output | DATA_W | Display register |

## Verification
The main collision is a section clear and the post-copy counter increment landing on the same edge at the end of phase 5. The bench provokes it by pulsing `sec_clr` during phase 5 with each `sec_sel` value. It then judges the outcome by the read and write addresses in the next step: the selected counter must read 0 and the other must have advanced. Clears placed between the read and the write, and `rec_en` toggled between those two slots, are judged the same way at the RAM pins and in the destination memory contents.

// File: rtl/rec_copy_ctrl.sv
module rec_copy_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_en,
  input  logic              sec_sel,
  input  logic              sec_clr,
  input  logic [DATA_W-1:0] led_in,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_ce,
  output logic [DATA_W-1:0] led_out
);
  localparam int HW = ADDR_W - 1;
  localparam int PH_W = 3;
  localparam logic [PH_W-1:0] LED_SLOT = 3'd0;
  localparam logic [PH_W-1:0] RD_SLOT  = 3'd2;
  localparam logic [PH_W-1:0] CAP_SLOT = 3'd3;
  localparam logic [PH_W-1:0] WR_SLOT  = 3'd5;

  logic [PH_W-1:0]   phase;
  logic [HW-1:0]     src_cnt, dst_cnt;
  logic              armed;
  logic [DATA_W-1:0] hold;

  wire rd_slot = (phase == RD_SLOT) && rec_en;
  wire wr_slot = (phase == WR_SLOT) && armed;

  assign ram_ce    = rd_slot | wr_slot;
  assign ram_we    = wr_slot;
  assign ram_wdata = hold;
  assign ram_addr  = wr_slot ? {1'b1, dst_cnt} :
                     rd_slot ? {1'b0, src_cnt} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      armed   <= 1'b0;
      hold    <= '0;
      led_out <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (phase == LED_SLOT) led_out <= led_in;
      if (phase == RD_SLOT) armed <= rec_en;
      else if (phase == WR_SLOT) armed <= 1'b0;
      if (phase == CAP_SLOT && armed) hold <= ram_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_cnt <= '0;
      dst_cnt <= '0;
    end else begin
      if (sec_clr && !sec_sel) src_cnt <= '0;
      else if (wr_slot)        src_cnt <= src_cnt + 1'b1;
      if (sec_clr && sec_sel)  dst_cnt <= '0;
      else if (wr_slot)        dst_cnt <= dst_cnt + 1'b1;
    end
  end

  p_we_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr[ADDR_W-1] && ram_ce));

  p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);

  p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(ram_ce && !ram_we, 3));

  p_led_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) != LED_SLOT) |-> $stable(led_out));

  p_clr_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_clr && !sec_sel) |=> (src_cnt == '0));

  p_clr_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_clr && sec_sel) |=> (dst_cnt == '0));

  p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !sec_clr) |=> (src_cnt == HW'($past(src_cnt) + 1'b1)));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce && !sec_clr) |=> (dst_cnt == $past(dst_cnt)));
endmodule

// File: tb/test_rec_copy_ctrl.sv
module test_rec_copy_ctrl;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NV = 12;

  // {pad, rec(phases 0..2), rec_late(3..7), clr, clr_phase, sel, led}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'hA5},
    {1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'h3C},
    {1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h0F},
    {1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 8'h11},
    {1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h22},
    {1'b0, 1'b1, 1'b1, 1'b1, 3'd5, 1'b1, 8'h33},
    {1'b0, 1'b1, 1'b1, 1'b1, 3'd7, 1'b0, 8'h44},
    {1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 8'h55},
    {1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 1'b1, 8'h66},
    {1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 8'h77},
    {1'b0, 1'b1, 1'b1, 1'b1, 3'd5, 1'b0, 8'h88},
    {1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'h99}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rec_en = 1'b0, sec_sel = 1'b0, sec_clr = 1'b0;
  logic [DW-1:0] led_in = '0;
  logic [DW-1:0] ram_rdata = '0;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, led_out;
  logic ram_we, ram_ce;

  logic [DW-1:0] mem [2**AW];
  int checks = 0, errors = 0;
  logic [AW-2:0] m_src = '0, m_dst = '0;
  logic [DW-1:0] m_led = '0;

  always #5 clk = ~clk;

  rec_copy_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_rec_copy_ctrl (
    .clk, .rst_n, .rec_en, .sec_sel, .sec_clr, .led_in, .ram_rdata,
    .ram_addr, .ram_wdata, .ram_we, .ram_ce, .led_out);

  always @(posedge clk) begin
    if (ram_ce && ram_we) mem[ram_addr] <= ram_wdata;
    else if (ram_ce) ram_rdata <= mem[ram_addr];
  end

  function automatic logic [DW-1:0] srcval(int i);
    return DW'((i * 37 + 11) ^ (i >> 2));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_step(input logic rec, input logic late, input logic clr,
                          input logic [2:0] cph, input logic sel, input logic [DW-1:0] led);
    logic armed = 1'b0;
    logic [AW-2:0] rsrc = '0, wdst = '0;
    for (int p = 0; p < 8; p++) begin
      rec_en  = (p <= 2) ? rec : late;
      sec_clr = clr && (p == int'(cph));
      sec_sel = sel;
      led_in  = led;
      #1;
      chk(led_out == m_led, "R2 led", led_out, m_led);
      if (p == 2) begin
        if (rec) begin
          chk(ram_ce && !ram_we, "R3 read strobe", {ram_ce, ram_we}, 2'b10);
          chk(ram_addr == {1'b0, m_src}, "R3 read addr", ram_addr, {1'b0, m_src});
        end else
          chk(!ram_ce && !ram_we, "R7 no read", {ram_ce, ram_we}, 0);
        armed = rec;
        rsrc = m_src;
      end else if (p == 5) begin
        if (armed) begin
          chk(ram_ce && ram_we, "R4 write strobe", {ram_ce, ram_we}, 2'b11);
          chk(ram_addr == {1'b1, m_dst}, "R4 write addr", ram_addr, {1'b1, m_dst});
          chk(ram_wdata == srcval(int'(rsrc)), "R4 write data", ram_wdata, srcval(int'(rsrc)));
        end else
          chk(!ram_ce && !ram_we, "R10 no write", {ram_ce, ram_we}, 0);
        wdst = m_dst;
      end else begin
        chk(!ram_ce && !ram_we, "R5 idle slot", {ram_ce, ram_we}, 0);
        if (p == 6 && armed)
          chk(mem[{1'b1, wdst}] == srcval(int'(rsrc)), "R4 dest content",
              mem[{1'b1, wdst}], srcval(int'(rsrc)));
      end
      if (ram_we) chk(ram_addr[AW-1], "R5 we in dest half", ram_addr, 0);
      @(negedge clk);
      if (p == 0) m_led = led;
      if (p == 5 && armed) begin
        m_src = m_src + 1'b1;
        m_dst = m_dst + 1'b1;
      end
      if (clr && p == int'(cph)) begin
        if (sel) m_dst = '0;
        else m_src = '0;
      end
    end
    sec_clr = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = (i < 2**(AW-1)) ? srcval(i) : '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!ram_ce && !ram_we, "R1 reset strobes", {ram_ce, ram_we}, 0);
    chk(led_out == '0, "R1 reset led", led_out, 0);
    rst_n = 1'b1;

    // R6 R8 R9 R10 exercised by the vector table
    for (int v = 0; v < NV; v++)
      run_step(VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][11:9], VEC[v][8], VEC[v][7:0]);

    // R6 wrap of both counters across the top of each half
    for (int s = 0; s < 2**(AW-1) + 3; s++)
      run_step(1'b1, 1'b1, 1'b0, 3'd0, 1'b0, DW'(s));

    // R1 R8 global reset mid-copy clears both counters
    run_step(1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'hC3);
    rec_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!ram_ce && !ram_we, "R1 reset mid-step", {ram_ce, ram_we}, 0);
    chk(led_out == '0, "R1 reset led mid-step", led_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_src = '0;
    m_dst = '0;
    m_led = '0;
    run_step(1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'h5E);
    run_step(1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 8'hE5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule